// File: doc/BRIEF.md
# Two-Level Write-One-To-Clear Interrupt Controller

The block gathers interrupt events into five secondary status registers. Most of them hold one bit per transmit queue. It condenses them into a primary status register. Each summary bit in the primary register is not stored. It is the OR of one group of secondary bits, taken through a per-bit secondary mask. The primary register also holds a set of directly latched event bits. A primary mask selects which primary bits may interrupt. A global enable register gates the single interrupt line. A read-only pending register reflects that line.

Every status register is write-one-to-clear. Writing a one to a summary bit clears its whole group of secondary bits at once. Software that must not lose events from other queues should therefore clear at the secondary level. The summary then drops by itself once its group is empty. An event that arrives in the same cycle as a clear of that bit is kept. All registers sit on a simple synchronous 32-bit register bus. Writes take effect at the clock edge and reads are combinational.

Top module: `icu_two_level`

## Requirements
- R1: A one on an event input sets the matching secondary bit at the next clock edge, and the bit stays set until cleared. The bit positions are:
  - secondary 0 (address 2): transmit-ok queue q at bit q, descriptor-done queue q at bit 16+q.
  - secondary 1 (address 3): transmit-error queue q at bit q, end-of-list queue q at bit 16+q.
  - secondary 2 (address 4): underrun queue q at bit q, host errors (master abort, system error, data parity) at bits 16..18, beacon events (TIM, DTIM, DTIM sync, beacon timeout, CAB timeout) at bits 24..28.
  - secondary 3 (address 5): CBR overrun queue q at bit q, CBR underrun queue q at bit 16+q.
  - secondary 4 (address 6): queue trigger queue q at bit q.
- R2: Writing a secondary status register clears exactly the bits written as one and leaves all other bits unchanged.
- R3: When an event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R4: Primary bits 16..25 are summaries, each the OR of (status AND secondary mask) over its group. The order is: transmit-ok, descriptor, transmit-error, end-of-list, underrun, host error, beacon misc, CBR overrun, CBR underrun, queue trigger.
- R5: Writing a one to a primary summary bit clears every bit of its secondary group and no other secondary bit.
- R6: Clearing all bits of a group at the secondary level clears the related summary bit with no primary write.
- R7: Direct event input d sets primary bit d (bits 0..ND-1). That bit is cleared only by writing a one to it at address 0.
- R8: irq_o is high exactly when the global enable is on and (primary status AND primary mask at address 1) is nonzero.
- R9: Writing 1 to the global enable register (address 12) turns it on and writing 0 turns it off. Any other value leaves it unchanged. Reading it returns its state in bit 0.
- R10: The pending register at address 13 reads 1 when irq_o is high and 0 otherwise.
- R11: After reset all status, mask and enable registers read zero and irq_o is low.
- R12: A secondary bit whose mask bit (addresses 7..11 for secondaries 0..4) is zero still latches and reads back, but does not contribute to its summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ev_txok | input | NQ | Per-queue transmit-ok events |
| ev_txdesc | input | NQ | Per-queue descriptor-done events |
| ev_txerr | input | NQ | Per-queue transmit-error events |
| ev_txeol | input | NQ | Per-queue end-of-list events |
| ev_txurn | input | NQ | Per-queue underrun events |
| ev_cbrorn | input | NQ | Per-queue CBR overrun events |
| ev_cbrurn | input | NQ | Per-queue CBR underrun events |
| ev_qtrig | input | NQ | Per-queue trigger events |
| ev_hiu | input | 3 | Host-interface errors: master abort, system error, data parity |
| ev_bcn | input | 5 | Beacon events: TIM, DTIM, DTIM sync, beacon timeout, CAB timeout |
| ev_direct | input | ND | Events latched straight into the primary register |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench drives an event into a bit in the same cycle that the bus writes a one to clear it. A design that let the clear win would silently drop an interrupt. It also clears one summary bit while a neighbouring group is populated. A design with the field masks mixed up would wipe the wrong queue bits or leave the group set. Secondary-level clears must drop the summary with no primary write, and a masked secondary bit must latch without raising its summary. Enable writes with values other than the two codes must change nothing, so a design that decoded only bit 0 would turn the line on.

// File: rtl/icu_pkg.sv
package icu_pkg;
   localparam int DW       = 32;
   localparam int AW       = 4;
   localparam int NSEC     = 5;
   localparam int NSUM     = 10;
   localparam int HI_BASE  = 16;
   localparam int SUM_BASE = 16;

   localparam int A_PSTAT  = 0;
   localparam int A_PMASK  = 1;
   localparam int A_SSTAT0 = 2;
   localparam int A_SMASK0 = 7;
   localparam int A_GEN    = 12;
   localparam int A_PEND   = 13;

   localparam logic [DW-1:0] GEN_ON_CODE  = 32'h0000_0001;
   localparam logic [DW-1:0] GEN_OFF_CODE = 32'h0000_0000;

   function automatic int sum_reg(input int i);
      case (i)
         0, 1:    return 0;
         2, 3:    return 1;
         4, 5, 6: return 2;
         7, 8:    return 3;
         default: return 4;
      endcase
   endfunction

   function automatic logic [DW-1:0] sum_field(input int i, input int nq);
      logic [DW-1:0] lo;
      lo = (DW'(1) << nq) - DW'(1);
      case (i)
         1, 3, 8: return lo << HI_BASE;
         5:       return DW'(32'h0007_0000);
         6:       return DW'(32'h1F00_0000);
         default: return lo;
      endcase
   endfunction
endpackage

// File: rtl/icu_w1c_reg.sv
module icu_w1c_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/icu_summary.sv
module icu_summary
   import icu_pkg::*;
#(
   parameter int NQ = 10
) (
   input  logic [NSEC-1:0][DW-1:0] sec_q,
   input  logic [NSEC-1:0][DW-1:0] sec_msk,
   output logic [NSUM-1:0]         sum_o
);
   for (genvar i = 0; i < NSUM; i++) begin : g_sum
      localparam int            RI  = sum_reg(i);
      localparam logic [DW-1:0] FLD = sum_field(i, NQ);
      assign sum_o[i] = |(sec_q[RI] & sec_msk[RI] & FLD);
   end
endmodule

// File: rtl/icu_two_level.sv
module icu_two_level
   import icu_pkg::*;
#(
   parameter int NQ = 10,
   parameter int ND = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic [NQ-1:0] ev_txok,
   input  logic [NQ-1:0] ev_txdesc,
   input  logic [NQ-1:0] ev_txerr,
   input  logic [NQ-1:0] ev_txeol,
   input  logic [NQ-1:0] ev_txurn,
   input  logic [NQ-1:0] ev_cbrorn,
   input  logic [NQ-1:0] ev_cbrurn,
   input  logic [NQ-1:0] ev_qtrig,
   input  logic [2:0]    ev_hiu,
   input  logic [4:0]    ev_bcn,
   input  logic [ND-1:0] ev_direct,
   output logic          irq_o
);
   initial begin
      assert (NQ >= 1 && NQ <= HI_BASE) else $error("NQ out of range");
      assert (ND >= 1 && ND <= SUM_BASE) else $error("ND out of range");
   end

   logic [NSEC-1:0][DW-1:0] sec_set, sec_clr, sec_q, sec_msk;
   logic [ND-1:0]           dir_q, dir_clr;
   logic [NSUM-1:0]         psum;
   logic [DW-1:0]           pmask, prim;
   logic                    gen_en;
   logic                    wr_prim;

   assign wr_prim = bus_wr && (bus_addr == AW'(A_PSTAT));

   always_comb begin
      sec_set = '0;
      sec_set[0][NQ-1:0]         = ev_txok;
      sec_set[0][HI_BASE +: NQ]  = ev_txdesc;
      sec_set[1][NQ-1:0]         = ev_txerr;
      sec_set[1][HI_BASE +: NQ]  = ev_txeol;
      sec_set[2][NQ-1:0]         = ev_txurn;
      sec_set[2][18:16]          = ev_hiu;
      sec_set[2][28:24]          = ev_bcn;
      sec_set[3][NQ-1:0]         = ev_cbrorn;
      sec_set[3][HI_BASE +: NQ]  = ev_cbrurn;
      sec_set[4][NQ-1:0]         = ev_qtrig;
   end

   always_comb begin
      for (int k = 0; k < NSEC; k++)
         sec_clr[k] = (bus_wr && bus_addr == AW'(A_SSTAT0 + k)) ? bus_wdata : '0;
      for (int i = 0; i < NSUM; i++)
         if (wr_prim && bus_wdata[SUM_BASE + i])
            sec_clr[sum_reg(i)] = sec_clr[sum_reg(i)] | sum_field(i, NQ);
   end

   for (genvar k = 0; k < NSEC; k++) begin : g_sec
      icu_w1c_reg #(.W(DW)) u_stat (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (sec_set[k]),
         .clr_i (sec_clr[k]),
         .q_o   (sec_q[k])
      );
      always_ff @(posedge clk) begin
         if (!rst_n) sec_msk[k] <= '0;
         else if (bus_wr && bus_addr == AW'(A_SMASK0 + k)) sec_msk[k] <= bus_wdata;
      end
   end

   assign dir_clr = wr_prim ? bus_wdata[ND-1:0] : '0;

   icu_w1c_reg #(.W(ND)) u_direct (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_direct),
      .clr_i (dir_clr),
      .q_o   (dir_q)
   );

   icu_summary #(.NQ(NQ)) u_sum (
      .sec_q   (sec_q),
      .sec_msk (sec_msk),
      .sum_o   (psum)
   );

   always_comb begin
      prim = '0;
      prim[ND-1:0]               = dir_q;
      prim[SUM_BASE +: NSUM]     = psum;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pmask  <= '0;
         gen_en <= 1'b0;
      end else if (bus_wr) begin
         if (bus_addr == AW'(A_PMASK)) pmask <= bus_wdata;
         if (bus_addr == AW'(A_GEN)) begin
            if (bus_wdata == GEN_ON_CODE)       gen_en <= 1'b1;
            else if (bus_wdata == GEN_OFF_CODE) gen_en <= 1'b0;
         end
      end
   end

   assign irq_o = gen_en && (|(prim & pmask));

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         AW'(A_PSTAT): bus_rdata = prim;
         AW'(A_PMASK): bus_rdata = pmask;
         AW'(A_GEN):   bus_rdata = {{(DW-1){1'b0}}, gen_en};
         AW'(A_PEND):  bus_rdata = {{(DW-1){1'b0}}, irq_o};
         default: begin
            for (int k = 0; k < NSEC; k++) begin
               if (bus_addr == AW'(A_SSTAT0 + k)) bus_rdata = sec_q[k];
               if (bus_addr == AW'(A_SMASK0 + k)) bus_rdata = sec_msk[k];
            end
         end
      endcase
   end
endmodule

// File: rtl/icu_two_level_chk.sv
module icu_two_level_chk
   import icu_pkg::*;
#(
   parameter int NQ = 10,
   parameter int ND = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_wr,
   input logic [AW-1:0]           bus_addr,
   input logic [DW-1:0]           bus_wdata,
   input logic [NQ-1:0]           ev_txok,
   input logic                    irq_o,
   input logic [ND-1:0]           dir_q,
   input logic [NSEC-1:0][DW-1:0] sec_q,
   input logic [NSUM-1:0]         psum,
   input logic                    gen_en
);
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_txok[0] |=> sec_q[0][0]); // R3

   AST_SEC_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(A_SSTAT0) && bus_wdata[0] && !ev_txok[0]) |=> !sec_q[0][0]); // R2

   AST_SUM_CLEARS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(A_PSTAT) && bus_wdata[SUM_BASE] && ev_txok == '0)
      |=> (sec_q[0][NQ-1:0] == '0)); // R5

   AST_DIRECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q[0] && !(bus_wr && bus_addr == AW'(A_PSTAT) && bus_wdata[0])) |=> dir_q[0]); // R7

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |-> !irq_o); // R8

   AST_SUM_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      psum[0] |-> (sec_q[0][NQ-1:0] != '0)); // R4
endmodule

bind icu_two_level icu_two_level_chk #(.NQ(NQ), .ND(ND)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .ev_txok   (ev_txok),
   .irq_o     (irq_o),
   .dir_q     (dir_q),
   .sec_q     (sec_q),
   .psum      (psum),
   .gen_en    (gen_en)
);

// File: tb/icu_two_level_bench.sv
module icu_two_level_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NQ = 10;
   localparam int ND = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NQ-1:0] ev_txok = '0, ev_txdesc = '0, ev_txerr = '0, ev_txeol = '0;
   logic [NQ-1:0] ev_txurn = '0, ev_cbrorn = '0, ev_cbrurn = '0, ev_qtrig = '0;
   logic [2:0] ev_hiu = '0;
   logic [4:0] ev_bcn = '0;
   logic [ND-1:0] ev_direct = '0;
   logic irq_o;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   icu_two_level #(.NQ(NQ), .ND(ND)) u_icu_two_level (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_txok(ev_txok), .ev_txdesc(ev_txdesc), .ev_txerr(ev_txerr), .ev_txeol(ev_txeol),
      .ev_txurn(ev_txurn), .ev_cbrorn(ev_cbrorn), .ev_cbrurn(ev_cbrurn), .ev_qtrig(ev_qtrig),
      .ev_hiu(ev_hiu), .ev_bcn(ev_bcn), .ev_direct(ev_direct), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic clear_all();
      wr(4'd0, 32'hFFFF_FFFF);
      for (int k = 2; k <= 6; k++) wr(4'(k), 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      for (int a = 0; a <= 13; a++) rd_check("R11 reset", 4'(a), 32'h0);
      check("R11 irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_latch();
      ev_txok[3] = 1'b1; ev_txdesc[9] = 1'b1; ev_hiu[1] = 1'b1; ev_bcn[4] = 1'b1;
      ev_qtrig[7] = 1'b1; ev_txeol[0] = 1'b1;
      tick();
      ev_txok = '0; ev_txdesc = '0; ev_hiu = '0; ev_bcn = '0; ev_qtrig = '0; ev_txeol = '0;
      tick();
      rd_check("R1 sec0", 4'd2, 32'h0200_0008);
      rd_check("R1 sec1", 4'd3, 32'h0001_0000);
      rd_check("R1 sec2", 4'd4, 32'h1002_0000);
      rd_check("R1 sec4", 4'd6, 32'h0000_0080);
   endtask

   task automatic t_w1c();
      wr(4'd2, 32'h0000_0008);
      rd_check("R2 sec0 partial clear", 4'd2, 32'h0200_0000);
      wr(4'd4, 32'h0002_0000);
      rd_check("R2 sec2 partial clear", 4'd4, 32'h1000_0000);
      clear_all();
   endtask

   task automatic t_set_wins();
      ev_txok[5] = 1'b1;
      ev_txok[0] = 1'b1;
      tick();
      ev_txok = '0;
      ev_txok[5] = 1'b1;
      wr(4'd2, 32'h0000_0021);
      ev_txok = '0;
      rd_check("R3 set beats clear", 4'd2, 32'h0000_0020);
      clear_all();
   endtask

   task automatic t_summary();
      for (int k = 7; k <= 11; k++) wr(4'(k), 32'hFFFF_FFFF);
      ev_txok[2] = 1'b1; ev_txdesc[1] = 1'b1; ev_txerr[0] = 1'b1; ev_hiu[2] = 1'b1;
      ev_bcn[0] = 1'b1; ev_cbrurn[4] = 1'b1;
      tick();
      ev_txok = '0; ev_txdesc = '0; ev_txerr = '0; ev_hiu = '0; ev_bcn = '0; ev_cbrurn = '0;
      rd_check("R4 summaries", 4'd0, 32'h0167_0000);
      wr(4'd0, 32'h0001_0000);
      rd_check("R5 group cleared", 4'd2, 32'h0002_0000);
      rd_check("R5 other reg kept", 4'd3, 32'h0000_0001);
      rd_check("R5 primary after", 4'd0, 32'h0166_0000);
      wr(4'd2, 32'h0002_0000);
      rd_check("R6 summary drops", 4'd0, 32'h0164_0000);
      clear_all();
      rd_check("R5 all clear", 4'd0, 32'h0);
   endtask

   task automatic t_mask();
      wr(4'd10, 32'hFFFF_0000);
      ev_cbrorn[0] = 1'b1;
      tick();
      ev_cbrorn = '0;
      rd_check("R12 masked bit latched", 4'd5, 32'h0000_0001);
      rd_check("R12 no summary", 4'd0, 32'h0);
      wr(4'd10, 32'hFFFF_FFFF);
      rd_check("R12 unmasked summary", 4'd0, 32'h0080_0000);
      clear_all();
   endtask

   task automatic t_direct();
      ev_direct[2] = 1'b1;
      tick();
      ev_direct = '0;
      tick();
      rd_check("R7 direct latched", 4'd0, 32'h0000_0004);
      wr(4'd0, 32'h0000_0001);
      rd_check("R7 other bit clear no effect", 4'd0, 32'h0000_0004);
      wr(4'd0, 32'h0000_0004);
      rd_check("R7 direct cleared", 4'd0, 32'h0);
   endtask

   task automatic t_irq();
      ev_direct[0] = 1'b1;
      tick();
      ev_direct = '0;
      wr(4'd1, 32'h0000_0001);
      check("R8 disabled no irq", {31'b0, irq_o}, 32'h0);
      wr(4'd12, 32'h0000_0005);
      check("R9 odd value ignored", {31'b0, irq_o}, 32'h0);
      rd_check("R9 enable readback off", 4'd12, 32'h0);
      wr(4'd12, 32'h0000_0001);
      check("R8 irq on", {31'b0, irq_o}, 32'h1);
      rd_check("R10 pending 1", 4'd13, 32'h1);
      wr(4'd12, 32'h0000_0003);
      check("R9 odd value keeps on", {31'b0, irq_o}, 32'h1);
      wr(4'd1, 32'h0000_0000);
      check("R8 masked no irq", {31'b0, irq_o}, 32'h0);
      rd_check("R10 pending 0", 4'd13, 32'h0);
      wr(4'd0, 32'h0000_0001);
      wr(4'd1, 32'h0200_0000);
      ev_qtrig[9] = 1'b1;
      tick();
      ev_qtrig = '0;
      check("R8 irq via summary", {31'b0, irq_o}, 32'h1);
      wr(4'd12, 32'h0000_0000);
      check("R9 disabled", {31'b0, irq_o}, 32'h0);
      rd_check("R10 pending after disable", 4'd13, 32'h0);
      clear_all();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_latch();
      t_w1c();
      t_set_wins();
      t_summary();
      t_mask();
      t_direct();
      t_irq();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule